// File: doc/BRIEF.md
# MDIO Management Station Controller

This block runs clause-22 management transactions to an external PHY over the two-wire MDC/MDIO link. Software sets a clock divisor and a preamble option in a control register. For a write it loads a data register, and then it writes a command word that carries the opcode, the PHY address and the register address. The command write starts the transaction on the same clock edge. A busy flag in the status register stays set until the frame is finished, and software polls it.

MDC is made by dividing the system clock. The divider counts half-periods, so the clock has a 50 % duty cycle. MDIO changes only on the falling edge of MDC and the PHY samples it on the rising edge. On a read, the engine releases the output enable from the turnaround onward. It shifts in sixteen data bits, most significant first, and puts the result in the data register in the same cycle that busy clears.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, the control register (address 0) reads divisor 32 in bits [7:0] and the suppression bit 16 as 0. The status register (address 3) bit 0 (busy) is 0. MDC is 0 and the MDIO output enable is 0.
- R2: A write to the command register (address 1) starts a transaction when bit 14 (read) or bit 15 (write) is set. Bits [4:0] hold the register address and bits [9:5] the PHY address. When both opcode bits are set, the transaction is a read. A command with neither bit set is ignored.
- R3: With suppression off, the frame is 32 ones, then start 01, then opcode 10 (read) or 01 (write), then the PHY address and the register address, each 5 bits MSB first, then turnaround, then 16 data bits. That makes 64 MDC periods.
- R4: With control bit 16 set, the 32 preamble ones are left out and the frame is 32 MDC periods long.
- R5: MDIO changes only while MDC is low and is held steady for the whole time MDC is high.
- R6: Each MDC half-period lasts H = divisor/2 system clocks (odd divisors round down). A divisor of 0 or 1 gives H = 1. A transaction of N bits keeps busy set for exactly 2·H·N clocks, and MDC is high for H·N of them.
- R7: Busy rises on the command edge and falls on the falling MDC edge that ends the last bit. While busy is clear, MDC stays low.
- R8: On a read, the output enable is released for the turnaround (2 bits) and the data (16 bits). The bits sampled on the sixteen data rising edges, MSB first, appear in the data register (address 2, bits [15:0]) when busy clears.
- R9: On a write, the turnaround is 10 and the data bits are the data register contents, MSB first. The data register keeps that value afterwards.
- R10: A command written while busy is set has no effect. The frame in flight, its length and its result are unchanged, and no further transaction follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 command, 2 data, 3 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value from the pad |

## Verification
The divisor sweep includes 0, 1-style clamping and an odd value. A divider that did not clamp would hang or never toggle, and one that did not round would stretch every half-period by a clock, so the busy length would be wrong. Every combination of read, write and preamble suppression is run, and each sampled bit is compared with the expected frame. This catches an off-by-one start index, a swapped opcode or a misplaced address field. Read data is driven by a bench PHY at every bit position, so a design that shifts in a bit early or late, or commits after busy clears, returns a shifted word. Some transactions get a second command while busy. A design that accepted it would corrupt the frame, change the busy length, or start a trailing transaction that the idle check sees.

// File: rtl/mdio_pkg.sv
// Package: mdio_pkg
// Shared constants and types for the MDIO management station.
// Assumes clause-22 framing: 5-bit PHY and register addresses and 16-bit data.
package mdio_pkg;
    localparam int FRAME_LEN = 64;          // bit slots including preamble
    localparam int PRE_LEN   = 32;          // preamble ones
    localparam int TA_POS    = 46;          // first turnaround slot
    localparam int DAT_POS   = 48;          // first data slot
    localparam int IDX_W     = $clog2(FRAME_LEN);
    localparam int ADR_W     = 5;
    localparam int DATA_W    = 16;

    localparam logic [1:0] SOF_BITS = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] TA_WRITE = 2'b10;
    localparam logic [1:0] TA_READ  = 2'b11;   // placeholder, never driven

    localparam logic [1:0] RA_CTRL = 2'd0;
    localparam logic [1:0] RA_CMD  = 2'd1;
    localparam logic [1:0] RA_DATA = 2'd2;
    localparam logic [1:0] RA_STAT = 2'd3;

    typedef struct packed {
        logic             rd;
        logic [ADR_W-1:0] phy;
        logic [ADR_W-1:0] regad;
    } mgmt_cmd_t;
endpackage

// File: rtl/mdio_clkgen.sv
// Module: mdio_clkgen
// Divides the system clock into MDC while run is high. It counts half-periods,
// so the duty cycle is 50 %. It gives one-cycle strobes on the edge where MDC
// rises or falls. Assumes divisor values below 2 mean a half-period of one clock.
module mdio_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] divisor,
    output logic             mdc,
    output logic             rise_stb,
    output logic             fall_stb
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] half;
    logic             wrap;
    logic             mdc_q;

    // Half-period length with clamping for divisors below two.
    always_comb begin
        half = (divisor < DIV_W'(2)) ? DIV_W'(1) : (divisor >> 1);
        wrap = (cnt >= half - DIV_W'(1));
    end

    // Half-period counter and MDC toggle; idle forces MDC low.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt   <= '0;
            mdc_q <= 1'b0;
        end else if (wrap) begin
            cnt   <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt   <= cnt + DIV_W'(1);
        end
    end

    // Edge strobes, valid in the cycle whose clock edge toggles MDC.
    always_comb begin
        rise_stb = run && wrap && !mdc_q;
        fall_stb = run && wrap &&  mdc_q;
        mdc      = mdc_q;
    end
endmodule

// File: rtl/mdio_frame_seq.sv
// Module: mdio_frame_seq
// Latches a management frame on start and walks it one slot per MDC period.
// The slot advances on the falling strobe and read bits are captured on the
// rising strobe. Assumes start is asserted for one cycle and only while idle.
module mdio_frame_seq
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  mgmt_cmd_t         cmd,
    input  logic [DATA_W-1:0] wdata,
    input  logic              no_pre,
    input  logic              rise_stb,
    input  logic              fall_stb,
    input  logic              mdio_i,
    output logic              busy,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              rd_done,
    output logic [DATA_W-1:0] rd_data
);
    logic [FRAME_LEN-1:0] frm;
    logic [IDX_W-1:0]     idx;
    logic                 is_rd;
    logic                 busy_q;
    logic [DATA_W-1:0]    cap;
    logic                 last_slot;
    logic                 rd_phase;

    // Slot decode shared by the output path and the sequencer.
    always_comb begin
        last_slot = (idx == IDX_W'(FRAME_LEN - 1));
        rd_phase  = is_rd && (idx >= IDX_W'(TA_POS));
    end

    // Frame latch, slot index and busy flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            idx    <= '0;
            frm    <= '1;
            is_rd  <= 1'b0;
        end else if (start && !busy_q) begin
            frm    <= {{PRE_LEN{1'b1}}, SOF_BITS,
                       cmd.rd ? OP_READ : OP_WRITE,
                       cmd.phy, cmd.regad,
                       cmd.rd ? TA_READ : TA_WRITE,
                       cmd.rd ? {DATA_W{1'b1}} : wdata};
            idx    <= no_pre ? IDX_W'(PRE_LEN) : '0;
            is_rd  <= cmd.rd;
            busy_q <= 1'b1;
        end else if (busy_q && fall_stb) begin
            if (last_slot) begin
                busy_q <= 1'b0;
            end else begin
                idx    <= idx + IDX_W'(1);
            end
        end
    end

    // Read data shift register, loaded on rising MDC in the data slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap <= '0;
        end else if (busy_q && rise_stb && is_rd && (idx >= IDX_W'(DAT_POS))) begin
            cap <= {cap[DATA_W-2:0], mdio_i};
        end
    end

    // Pad outputs and completion strobe.
    always_comb begin
        busy    = busy_q;
        mdio_o  = busy_q ? frm[IDX_W'(FRAME_LEN - 1) - idx] : 1'b1;
        mdio_oe = busy_q && !rd_phase;
        rd_done = busy_q && fall_stb && last_slot && is_rd;
        rd_data = cap;
    end

    // R10: the latched frame cannot change once a transaction is running.
    a_r10_frame_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && $past(busy_q) && $past(rst_n)) |-> ($stable(frm) && $stable(is_rd)));
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
// Module: mdio_mgmt_ctrl
// Register-driven MDIO management station. It holds the control and data
// registers, decodes command writes into a frame start, and joins the MDC
// divider and the frame sequencer. Assumes DIV_W <= 16 so that the divisor
// field stays below the suppression bit.
module mdio_mgmt_ctrl
    import mdio_pkg::*;
#(
    parameter int DIV_W     = 8,
    parameter int DIV_RESET = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr_en,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    localparam int NOPRE_BIT = 16;
    localparam int RD_BIT    = 14;
    localparam int WR_BIT    = 15;
    localparam int PHY_LSB   = 5;

    logic [DIV_W-1:0]  div_q;
    logic              nopre_q;
    logic [DATA_W-1:0] data_q;
    logic              busy;
    logic              start;
    mgmt_cmd_t         cmd;
    logic              rise_stb;
    logic              fall_stb;
    logic              rd_done;
    logic [DATA_W-1:0] rd_data;
    logic [31:0]       ctrl_view;

    // Command decode; a write with no opcode bit or while busy does nothing.
    always_comb begin
        cmd.rd    = reg_wdata[RD_BIT];
        cmd.phy   = reg_wdata[PHY_LSB +: ADR_W];
        cmd.regad = reg_wdata[ADR_W-1:0];
        start     = reg_wr_en && (reg_addr == RA_CMD) && !busy &&
                    (reg_wdata[RD_BIT] || reg_wdata[WR_BIT]);
    end

    // Control register: divisor and preamble suppression.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q   <= DIV_W'(DIV_RESET);
            nopre_q <= 1'b0;
        end else if (reg_wr_en && reg_addr == RA_CTRL) begin
            div_q   <= reg_wdata[DIV_W-1:0];
            nopre_q <= reg_wdata[NOPRE_BIT];
        end
    end

    // Data register: loaded by software or by a finished read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (rd_done) begin
            data_q <= rd_data;
        end else if (reg_wr_en && reg_addr == RA_DATA) begin
            data_q <= reg_wdata[DATA_W-1:0];
        end
    end

    // Register read mux; the command register reads as zero.
    always_comb begin
        ctrl_view                = '0;
        ctrl_view[DIV_W-1:0]     = div_q;
        ctrl_view[NOPRE_BIT]     = nopre_q;
        case (reg_addr)
            RA_CTRL: reg_rdata = ctrl_view;
            RA_DATA: reg_rdata = {{(32-DATA_W){1'b0}}, data_q};
            RA_STAT: reg_rdata = {31'd0, busy};
            default: reg_rdata = '0;
        endcase
    end

    mdio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .divisor  (div_q),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_frame_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cmd      (cmd),
        .wdata    (data_q),
        .no_pre   (nopre_q),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb),
        .mdio_i   (mdio_i),
        .busy     (busy),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .rd_done  (rd_done),
        .rd_data  (rd_data)
    );

    // R7: MDC is parked low whenever no transaction runs.
    a_r7_idle_mdc_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    // R7: a transaction ends together with a falling MDC edge.
    a_r7_end_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && $past(rst_n)) |-> $fell(mdc));

    // R5: MDIO holds its value through each high phase of MDC.
    a_r5_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mdc && $past(mdc) && $past(rst_n)) |-> $stable(mdio_o));

    // R8: the read result is committed only while the station listens.
    a_r8_listen_at_commit: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> !mdio_oe);
endmodule

// File: tb/mdio_mgmt_ctrl_test.sv
module mdio_mgmt_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_addr = 2'd3;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;   // 50 MHz

    mdio_mgmt_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // Watchdog: a hung run is reported as a failed check.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 150000) begin
            errors = errors + 1;
            $display("FAIL R7 watchdog: run did not end actual=%0d expected<%0d", cycles, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_addr = 2'd3;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a; #1; d = reg_rdata; reg_addr = 2'd3;
    endtask

    // Expected MDIO value in frame slot p.
    function automatic logic exp_bit(int p, logic is_rd, logic [4:0] phy,
                                     logic [4:0] ra, logic [15:0] wd);
        if (p < 32) return 1'b1;
        if (p == 32) return 1'b0;
        if (p == 33) return 1'b1;
        if (p == 34) return is_rd;
        if (p == 35) return !is_rd;
        if (p <= 40) return phy[4 - (p - 36)];
        if (p <= 45) return ra[4 - (p - 41)];
        if (p == 46) return 1'b1;
        if (p == 47) return 1'b0;
        return wd[63 - p];
    endfunction

    task automatic txn(input int div, input logic nopre, input logic is_rd, input logic both,
                       input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] wd,
                       input logic [15:0] rv, input logic inject);
        int st, n, h, cyc, rises, highs;
        logic prev, busy;
        logic [63:0] got_b, got_oe, exp_b, exp_oe, seen, mask;
        logic [31:0] r, cmdw;
        st = nopre ? 32 : 0;
        n = 64 - st;
        h = (div < 2) ? 1 : div / 2;
        got_b = '0; got_oe = '0; seen = '0; exp_b = '0; exp_oe = '0; mask = '0;
        wr(2'd0, {15'd0, nopre, 8'd0, 8'(div)});
        wr(2'd2, {16'd0, wd});
        mdio_i = 1'b1;
        cmdw = {16'd0, !is_rd || both, is_rd, 4'd0, phy, ra};
        wr(2'd1, cmdw);
        rd(2'd3, r);
        chk("R7 busy set on command edge", {63'd0, r[0]}, 64'd1);
        cyc = 0; rises = 0; highs = 0; prev = 1'b0;
        forever begin
            reg_wr_en = 1'b0; reg_addr = 2'd3; #1;
            busy = reg_rdata[0];
            if (!busy || cyc > 20000) break;
            cyc++;
            if (mdc) highs++;
            if (mdc && !prev) begin
                seen[st + rises] = 1'b1;
                got_b[st + rises] = mdio_o;
                got_oe[st + rises] = mdio_oe;
                rises++;
                if (st + rises >= 48 && st + rises < 64) mdio_i = rv[63 - (st + rises)];
                else mdio_i = 1'b1;
            end
            prev = mdc;
            if (inject && cyc == 3) begin
                reg_wr_en = 1'b1; reg_addr = 2'd1;
                reg_wdata = {16'd0, 1'b1, 1'b1, 4'd0, ~phy, ~ra};
            end
            @(negedge clk);
        end
        for (int p = st; p < 64; p++) begin
            exp_oe[p] = !(is_rd && p >= 46);
            if (exp_oe[p]) begin
                mask[p] = 1'b1;
                exp_b[p] = exp_bit(p, is_rd, phy, ra, wd);
            end
        end
        chk(nopre ? "R4 slots observed" : "R3 slots observed", seen, {64{1'b1}} << st);
        chk(nopre ? "R4 frame bits" : "R3 frame bits", got_b & mask, exp_b & mask);
        chk("R8 output enable pattern", got_oe & seen, exp_oe);
        chk("R6 busy length", 64'(cyc), 64'(2 * h * n));
        chk("R6 mdc high clocks", 64'(highs), 64'(h * n));
        rd(2'd2, r);
        if (is_rd) chk("R8 read result", 64'(r[15:0]), 64'(rv));
        else       chk("R9 data kept after write", 64'(r[15:0]), 64'(wd));
        repeat (6) @(negedge clk);
        rd(2'd3, r);
        chk(inject ? "R10 no trailing transaction" : "R7 idle after end", {62'd0, mdc, r[0]}, 64'd0);
    endtask

    initial begin
        logic [31:0] r;
        int idx;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(2'd0, r);
        chk("R1 control reset value", 64'(r), 64'd32);
        rd(2'd3, r);
        chk("R1 busy clear", 64'(r), 64'd0);
        chk("R1 pads idle", {62'd0, mdc, mdio_oe}, 64'd0);

        // R2: a command with no opcode bit is ignored.
        wr(2'd1, 32'h0000_03FF);
        rd(2'd3, r);
        chk("R2 no-opcode command ignored", {62'd0, mdc, r[0]}, 64'd0);
        repeat (5) @(negedge clk);
        chk("R2 mdc quiet after ignored command", {63'd0, mdc}, 64'd0);

        idx = 0;
        for (int d = 0; d < 6; d++) begin
            for (int k = 0; k < 4; k++) begin
                int div;
                logic [15:0] wd;
                case (d)
                    0: div = 2;
                    1: div = 4;
                    2: div = 5;
                    3: div = 32;
                    4: div = 0;
                    default: div = 6;
                endcase
                wd = 16'hA5C3 ^ 16'(idx * 16'h1357);
                txn(div, k[1], k[0], (k == 3), 5'((idx * 7 + 3) & 31), 5'((idx * 11 + 5) & 31),
                    wd, ~wd, (idx % 3 == 0));
                idx++;
            end
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule